// File: doc/BRIEF.md
# Processor Run/Halt Debug Controller

This block decides when a small processor core may advance. It sits beside the core, watches the fetch address and a break-instruction flag, and drives a single run-enable line. A host reaches it through a word-wide register port with separate read and write enables, a 17-bit byte address and 32-bit data. Two registers are visible: a control word and a stop-address word.

The control word mixes three kinds of bit. One bit is read-only status that tells whether the core is stopped. Three bits are one-shot commands: launch, continue and stop. They act only in the cycle they are written and always read back as zero. Two bits are sticky arming flags that stop the core on a break instruction or on a fetch from the stop address. The usual sequence is as follows. Load the stop address. Write launch plus address arming (0x22). Poll until stopped. Inspect the core. Then write launch, continue and address arming (0x26) to carry on from the stop point without tripping again on the same fetch.

Top module: `dbg_halt_ctl`

## Requirements
- R1: After synchronous reset the core is stopped: `coreRun` is 0, the control word reads 0x00000001, the stop address reads 0, and `cpRdata` is 0.
- R2: A register is selected only when address bits [16:14] are 100 and bits [1:0] are 00. Bits [13:2] give the index: 0 is the control word and 1 is the stop address. Writes to any other address change nothing, and reads of any other address return 0.
- R3: Control-word layout: bit 0 is the stopped flag (read-only), bit 1 is launch, bit 2 is continue and bit 3 is stop. Bits 1 to 3 are write-only and read 0. Bit 4 arms break stopping and bit 5 arms address stopping; both read back as written. All other bits read 0.
- R4: A launch write while stopped raises `coreRun` after the write edge. A read presented in the next cycle returns the stopped flag as 0.
- R5: With address stopping armed and the core running, a fetch address equal to the stop address drops `coreRun` in that same cycle, and the stopped flag is set at the next edge.
- R6: With break stopping armed and the core running, an asserted `coreBrk` drops `coreRun` in that same cycle, and the stopped flag is set at the next edge.
- R7: A condition whose arming bit is clear never stops the core. Address comparison uses all 32 bits.
- R8: A continue write while stopped restarts the core. Both stop conditions are masked while the fetch address still equals the address held when continuing. Once the fetch address differs from it, the conditions are re-armed.
- R9: A stop write stops the core at the next edge. In the same write it overrides launch and continue.
- R10: `cpRdata` is registered. It shows the selected word one cycle after `cpRe` is presented and holds its value while `cpRe` is low.
- R11: A launch write without continue does not mask anything. Launching with the fetch address already equal to an armed stop address stops the core at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpRe | input | 1 | Register read enable |
| cpWe | input | 1 | Register write enable |
| cpAddr | input | 17 | Register byte address |
| cpWdata | input | 32 | Write data |
| cpRdata | output | 32 | Registered read data |
| corePc | input | 32 | Core fetch address |
| coreBrk | input | 1 | Core is fetching a break instruction |
| coreRun | output | 1 | Core may advance this cycle |

## Verification
The stop logic is exercised with a vector set that crosses both arming bits against matching and non-matching fetch addresses and against an asserted or quiet break flag. This separates each condition's own effect from its arming bit. One vector differs only in the top address bit, so a truncated comparator is caught. Directed sequences then contrast launch with continue at a matching address, which exposes a missing or sticky step-past mask. They also put stop together with the other commands in one write to expose wrong priority, and use off-map and misaligned addresses to expose loose decoding.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  // Control-word bit positions (host software depends on these)
  localparam int BIT_HALTED = 0;
  localparam int BIT_START  = 1;
  localparam int BIT_RESUME = 2;
  localparam int BIT_STOP   = 3;
  localparam int BIT_EN_BRK = 4;
  localparam int BIT_EN_ADR = 5;

  localparam int         PREFIX_W = 3;
  localparam logic [2:0] PREFIX   = 3'b100;

  typedef enum logic [1:0] {
    RUN_HALTED = 2'd0,
    RUN_ACTIVE = 2'd1,
    RUN_STEP   = 2'd2
  } run_state_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic wrCtrl;
    logic wrAddr;
    logic rdEn;
    logic rdCtrl;
    logic rdAddr;
    logic latchPc;
  } dbg_strobe_t;

  // Datapath -> control status
  typedef struct packed {
    logic hitRaw;
    logic pcMoved;
  } dbg_stat_t;

endpackage

// File: rtl/dbg_halt_dp.sv
module dbg_halt_dp
  import dbg_halt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  dbg_strobe_t       stb,
  input  logic              isHalted,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PC_W-1:0]   corePc,
  input  logic              coreBrk,
  output dbg_stat_t         stat,
  output logic [DATA_W-1:0] rdata
);

  logic            enBrk;
  logic            enAdr;
  logic [PC_W-1:0] haltAddr;
  logic [PC_W-1:0] skipPc;
  logic [DATA_W-1:0] ctrlWord;

  // Arming flags persist until the control word is rewritten
  always_ff @(posedge clk) begin
    if (rst) begin
      enBrk <= 1'b0;
      enAdr <= 1'b0;
    end else if (stb.wrCtrl) begin
      enBrk <= wdata[BIT_EN_BRK];
      enAdr <= wdata[BIT_EN_ADR];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) haltAddr <= '0;
    else if (stb.wrAddr) haltAddr <= wdata[PC_W-1:0];
  end

  // Fetch address captured when continuing from a stop
  always_ff @(posedge clk) begin
    if (rst) skipPc <= '0;
    else if (stb.latchPc) skipPc <= corePc;
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_HALTED] = isHalted;
    ctrlWord[BIT_EN_BRK] = enBrk;
    ctrlWord[BIT_EN_ADR] = enAdr;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (stb.rdEn) begin
      if (stb.rdCtrl)      rdata <= ctrlWord;
      else if (stb.rdAddr) rdata <= DATA_W'(haltAddr);
      else                 rdata <= '0;
    end
  end

  assign stat.hitRaw  = (enAdr && (corePc == haltAddr)) || (enBrk && coreBrk);
  assign stat.pcMoved = (corePc != skipPc);

  AST_ARM_WRITE: assert property (@(posedge clk) disable iff (rst)
    stb.wrCtrl |=> (enAdr == $past(wdata[BIT_EN_ADR])) && (enBrk == $past(wdata[BIT_EN_BRK]))); // R3
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (stb.rdEn && stb.rdCtrl) |=> (rdata[BIT_STOP:BIT_START] == 3'b000)); // R3
  AST_ADDR_WRITE: assert property (@(posedge clk) disable iff (rst)
    stb.wrAddr |=> (haltAddr == $past(wdata[PC_W-1:0]))); // R2
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb.rdEn |=> $stable(rdata)); // R10

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int CTRL_IDX = 0,
  parameter int HADR_IDX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpRe,
  input  logic              cpWe,
  input  logic [ADDR_W-1:0] cpAddr,
  input  logic [2:0]        cmdBits,   // {stop, resume, start}
  input  dbg_stat_t         stat,
  output dbg_strobe_t       stb,
  output logic              coreRun,
  output logic              isHalted
);

  localparam int IDX_W = ADDR_W - PREFIX_W - 2;

  logic             mapOk;
  logic [IDX_W-1:0] regIdx;
  logic             selCtrl, selAddr;
  logic             cmdStart, cmdResume, cmdStop;
  logic             condHit;
  run_state_t       state, stateNxt;

  assign mapOk   = (cpAddr[ADDR_W-1 -: PREFIX_W] == PREFIX) && (cpAddr[1:0] == 2'b00);
  assign regIdx  = cpAddr[ADDR_W-PREFIX_W-1:2];
  assign selCtrl = mapOk && (regIdx == IDX_W'(CTRL_IDX));
  assign selAddr = mapOk && (regIdx == IDX_W'(HADR_IDX));

  assign cmdStart  = cpWe && selCtrl && cmdBits[0];
  assign cmdResume = cpWe && selCtrl && cmdBits[1];
  assign cmdStop   = cpWe && selCtrl && cmdBits[2];

  // Enabled stop condition, masked while stepping off the resume address
  always_comb begin
    case (state)
      RUN_ACTIVE: condHit = stat.hitRaw;
      RUN_STEP:   condHit = stat.hitRaw && stat.pcMoved;
      default:    condHit = 1'b0;
    endcase
  end

  always_comb begin
    stateNxt = state;
    case (state)
      RUN_HALTED: begin
        if (cmdStop)        stateNxt = RUN_HALTED;
        else if (cmdResume) stateNxt = RUN_STEP;
        else if (cmdStart)  stateNxt = RUN_ACTIVE;
      end
      RUN_ACTIVE: begin
        if (cmdStop || condHit) stateNxt = RUN_HALTED;
      end
      RUN_STEP: begin
        if (cmdStop || condHit) stateNxt = RUN_HALTED;
        else if (stat.pcMoved)  stateNxt = RUN_ACTIVE;
      end
      default: stateNxt = RUN_HALTED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= RUN_HALTED;
    else     state <= stateNxt;
  end

  assign isHalted = (state == RUN_HALTED);
  assign coreRun  = !isHalted && !condHit;

  always_comb begin
    stb.wrCtrl  = cpWe && selCtrl;
    stb.wrAddr  = cpWe && selAddr;
    stb.rdEn    = cpRe;
    stb.rdCtrl  = selCtrl;
    stb.rdAddr  = selAddr;
    stb.latchPc = isHalted && cmdResume && !cmdStop;
  end

  AST_RESET_HALTED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> isHalted); // R1
  AST_HIT_STOPS: assert property (@(posedge clk) disable iff (rst)
    condHit |=> (state == RUN_HALTED)); // R5
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
    cmdStop |=> (state == RUN_HALTED)); // R9
  AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
    (isHalted && cmdStart && !cmdResume && !cmdStop) |=> (state == RUN_ACTIVE)); // R4
  AST_RESUME_STEPS: assert property (@(posedge clk) disable iff (rst)
    (isHalted && cmdResume && !cmdStop) |=> (state == RUN_STEP)); // R8

endmodule

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl
  import dbg_halt_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  parameter int CTRL_IDX = 0,
  parameter int HADR_IDX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpRe,
  input  logic              cpWe,
  input  logic [ADDR_W-1:0] cpAddr,
  input  logic [DATA_W-1:0] cpWdata,
  output logic [DATA_W-1:0] cpRdata,
  input  logic [PC_W-1:0]   corePc,
  input  logic              coreBrk,
  output logic              coreRun
);

  dbg_strobe_t stb;
  dbg_stat_t   stat;
  logic        isHalted;

  dbg_halt_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_IDX(CTRL_IDX), .HADR_IDX(HADR_IDX)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cpRe(cpRe), .cpWe(cpWe), .cpAddr(cpAddr),
    .cmdBits(cpWdata[BIT_STOP:BIT_START]), .stat(stat), .stb(stb),
    .coreRun(coreRun), .isHalted(isHalted)
  );

  dbg_halt_dp #(
    .DATA_W(DATA_W), .PC_W(PC_W)
  ) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .isHalted(isHalted), .wdata(cpWdata),
    .corePc(corePc), .coreBrk(coreBrk), .stat(stat), .rdata(cpRdata)
  );

endmodule

// File: tb/sim_dbg_halt_ctl.sv
`timescale 1ns/1ps
module sim_dbg_halt_ctl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpRe = 1'b0;
  logic        cpWe = 1'b0;
  logic [16:0] cpAddr = '0;
  logic [31:0] cpWdata = '0;
  logic [31:0] cpRdata;
  logic [31:0] corePc = '0;
  logic        coreBrk = 1'b0;
  logic        coreRun;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbg_halt_ctl u0 (
    .clk(clk), .rst(rst), .cpRe(cpRe), .cpWe(cpWe), .cpAddr(cpAddr),
    .cpWdata(cpWdata), .cpRdata(cpRdata), .corePc(corePc),
    .coreBrk(coreBrk), .coreRun(coreRun)
  );

  localparam logic [16:0] A_CTRL = {3'b100, 12'd0, 2'b00};
  localparam logic [16:0] A_HADR = {3'b100, 12'd1, 2'b00};
  localparam logic [31:0] C_START = 32'h02, C_RESUME = 32'h04, C_STOP = 32'h08;
  localparam logic [31:0] C_EBRK = 32'h10, C_EADR = 32'h20;

  // {enBrk, enAdr, stopAddr, pc, brk, expectRun}
  localparam int NV = 8;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0000_0100, 32'h0000_0100, 1'b1, 1'b1},
    {1'b0, 1'b1, 32'h0000_0200, 32'h0000_0200, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'h0000_0200, 32'h0000_0204, 1'b0, 1'b1},
    {1'b1, 1'b0, 32'h0000_0300, 32'h0000_0040, 1'b1, 1'b0},
    {1'b1, 1'b0, 32'h0000_0300, 32'h0000_0300, 1'b0, 1'b1},
    {1'b1, 1'b1, 32'h0000_0400, 32'h0000_0408, 1'b1, 1'b0},
    {1'b1, 1'b1, 32'h0000_0400, 32'h0000_0400, 1'b0, 1'b0},
    {1'b0, 1'b1, 32'hFFFF_FFFC, 32'h7FFF_FFFC, 1'b0, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cpWrite(input logic [16:0] a, input logic [31:0] d);
    @(negedge clk);
    cpWe = 1'b1; cpAddr = a; cpWdata = d;
    @(negedge clk);
    cpWe = 1'b0; cpWdata = '0;
  endtask

  task automatic cpRead(input logic [16:0] a, output logic [31:0] v);
    @(negedge clk);
    cpRe = 1'b1; cpAddr = a;
    @(negedge clk);
    cpRe = 1'b0;
    v = cpRdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 coreRun", {31'b0, coreRun}, 32'h0);
    check("R1 rdata", cpRdata, 32'h0);
    cpRead(A_CTRL, v); check("R1 ctrl", v, 32'h1);
    cpRead(A_HADR, v); check("R1 addr", v, 32'h0);

    // R3 layout / R2 stop-address readback
    cpWrite(A_CTRL, 32'hFFFF_FF30);
    cpRead(A_CTRL, v); check("R3 arm bits", v, 32'h31);
    cpWrite(A_HADR, 32'h1234_5678);
    cpRead(A_HADR, v); check("R2 addr rw", v, 32'h1234_5678);

    // R2 off-map and misaligned accesses
    cpWrite({3'b000, 12'd1, 2'b00}, 32'hAAAA_AAAA);
    cpWrite({3'b100, 12'd1, 2'b01}, 32'h5555_5555);
    cpRead(A_HADR, v); check("R2 ignored write", v, 32'h1234_5678);
    cpRead({3'b100, 12'd7, 2'b00}, v); check("R2 unmapped read", v, 32'h0);
    cpWrite({3'b100, 12'd2, 2'b00}, C_START);
    check("R2 no start", {31'b0, coreRun}, 32'h0);
    cpWrite(A_CTRL, 32'h0);

    // Vector table: R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      cpWrite(A_HADR, VEC[i][65:34]);
      corePc = VEC[i][33:2]; coreBrk = VEC[i][1];
      cpWrite(A_CTRL, C_START | (VEC[i][67] ? C_EBRK : 32'h0) | (VEC[i][66] ? C_EADR : 32'h0));
      check($sformatf("R5 R6 R7 run vec%0d", i), {31'b0, coreRun}, {31'b0, VEC[i][0]});
      cpRead(A_CTRL, v);
      check($sformatf("R5 R6 R7 flag vec%0d", i), {31'b0, v[0]}, {31'b0, ~VEC[i][0]});
      cpWrite(A_CTRL, C_STOP);
      coreBrk = 1'b0;
    end

    // R4 start, and R10 read hold
    cpRead(A_CTRL, v); check("R10 before", v, 32'h1);
    cpWrite(A_CTRL, C_START);
    check("R4 run", {31'b0, coreRun}, 32'h1);
    check("R10 hold", cpRdata, 32'h1);
    cpRead(A_CTRL, v); check("R4 flag clear", v, 32'h0);

    // R9 stop command while running
    cpWrite(A_CTRL, C_STOP);
    check("R9 stop run", {31'b0, coreRun}, 32'h0);
    cpRead(A_CTRL, v); check("R9 stop flag", v, 32'h1);
    // R9 priority over start and resume
    cpWrite(A_CTRL, C_START | C_RESUME | C_STOP);
    check("R9 priority", {31'b0, coreRun}, 32'h0);
    cpRead(A_CTRL, v); check("R9 priority flag", v, 32'h1);

    // R11 launch at matching address stops at once
    cpWrite(A_HADR, 32'h100);
    corePc = 32'h100;
    cpWrite(A_CTRL, C_START | C_EADR);
    check("R11 run", {31'b0, coreRun}, 32'h0);
    cpRead(A_CTRL, v); check("R11 flag", v, 32'h21);

    // R8 continue steps past the matched address
    cpWrite(A_CTRL, C_START | C_RESUME | C_EADR);
    check("R8 step run", {31'b0, coreRun}, 32'h1);
    cpRead(A_CTRL, v); check("R8 step flag", v, 32'h20);
    @(negedge clk); corePc = 32'h104;
    #1 check("R8 moved", {31'b0, coreRun}, 32'h1);
    @(negedge clk); corePc = 32'h100;
    #1 check("R8 rearmed run", {31'b0, coreRun}, 32'h0);
    cpRead(A_CTRL, v); check("R8 rearmed flag", v, 32'h21);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule